// File: doc/BRIEF.md
# MSI Message Queue Controller

The controller sits between an inbound message-signalled interrupt path and system memory. Every interrupt message it accepts is turned into a 16-byte record and written into a circular queue in host memory. Software owns the queue's base address and its size, selected from four powers of two. The hardware owns the write offset and software owns the read offset. A single level interrupt tells the host that records are waiting or that the queue has filled.

Software programs the base address and the size code. It then sets the enable bits. When the interrupt fires, software walks records from its read offset up to the write offset the block reports, and writes back the new read offset. When the queue is full, the block can either keep logging, which overwrites unread records, or stop and drop new messages while it raises a sticky flag.

Top module: `msi_queue_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: Register selects are 0 control, 3 base high, 4 base low, 5 read offset and 6 write offset. The control bits are: bit 0 enable, bit 1 full-interrupt enable, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size code, and bit 16 the sticky dropped-on-full flag, which is read-only. Base-low bits 3:0 always read zero.
- R3: When enabled and idle, a message with `msi_valid` high issues exactly one memory write. Its address is base + write offset. `mem_data` bits 15:0 carry `msi_data[15:0]`, so byte 0 is the low byte, and bits 127:16 are zero.
- R4: `mem_req` and its address and data hold until `mem_ack` is high on a clock edge. Only then does the write offset advance by 0x10. Messages that arrive while a write is outstanding are ignored.
- R5: The size is 2^(code+15) bytes. The write offset wraps to zero when it advances from size-0x10.
- R6: Writes to the read offset and write offset registers are stored masked to 16-byte alignment and to the current size. Readback of either offset is masked to the current size.
- R7: `irq` is high when enable and interrupt enable are set and the read offset differs from the write offset.
- R8: The queue is full when (write offset + 0x10) masked to the size equals the read offset. With enable and full-interrupt enable set, `irq` is high while the queue is full.
- R9: With stop-on-full set and the queue full, a message is dropped: no memory write is issued and the write offset is unchanged. The sticky flag (control bit 16) is set. Writing control with bit 16 set clears it.
- R10: With enable clear, messages are ignored and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| msi_valid | input | 1 | Inbound interrupt message strobe |
| msi_data | input | 32 | Inbound message data word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 128 | 16-byte record, little-endian |
| mem_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | Summary interrupt, level high |

## Verification
A corrupted write offset shows up on the next accepted message as a wrong `mem_addr`, and at once in write-offset readback. A bad size mask shows up as a failure to wrap to zero at the queue edge, or as readback bits above the size. A wrong full comparison shows up as `irq` being high or low in the wrong state on the cycle of the register write that creates the condition. It also shows up as a memory request issued, or withheld, one cycle after the message. A stuck busy state shows up as a missing request on the next message.

// File: rtl/msi_queue_ctrl.sv
module msi_queue_ctrl #(
  parameter int OFF_W = 18,
  parameter int MIN_SHIFT = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         msi_valid,
  input  logic [31:0]  msi_data,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  input  logic         mem_ack,
  output logic         irq
);
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_BHI  = 3'd3;
  localparam logic [2:0] SEL_BLO  = 3'd4;
  localparam logic [2:0] SEL_ROFF = 3'd5;
  localparam logic [2:0] SEL_WOFF = 3'd6;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(16);
  localparam logic [OFF_W-1:0] ONE  = OFF_W'(1);

  logic              en_q, fen_q, ien_q, sen_q, sticky_q;
  logic [1:0]        size_q;
  logic [31:0]       base_hi_q;
  logic [27:0]       base_lo_q;
  logic [OFF_W-1:0]  roff_q, woff_q;
  logic              req_q;
  logic [63:0]       addr_q;
  logic [15:0]       rec_q;

  logic [OFF_W-1:0]  off_mask, roff_m, woff_m, woff_nx;
  logic              full, nonempty, idle_msg, accept, drop_full;

  assign off_mask = ((ONE << (MIN_SHIFT + int'(size_q))) - ONE) & ~OFF_W'(15);
  assign roff_m   = roff_q & off_mask;
  assign woff_m   = woff_q & off_mask;
  assign woff_nx  = (woff_m + STEP) & off_mask;
  assign full     = (woff_nx == roff_m);
  assign nonempty = (roff_m != woff_m);

  assign idle_msg  = msi_valid && en_q && !req_q;
  assign accept    = idle_msg && !(sen_q && full);
  assign drop_full = idle_msg && sen_q && full;

  assign irq      = en_q && ((ien_q && nonempty) || (fen_q && full));
  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign mem_data = {112'd0, rec_q};

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_addr)
      SEL_CTRL: reg_rdata = {15'd0, sticky_q, 6'd0, size_q, 3'd0, sen_q, ien_q, 1'b0, fen_q, en_q};
      SEL_BHI:  reg_rdata = base_hi_q;
      SEL_BLO:  reg_rdata = {base_lo_q, 4'd0};
      SEL_ROFF: reg_rdata = 32'(roff_m);
      SEL_WOFF: reg_rdata = 32'(woff_m);
      default:  reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; fen_q <= 1'b0; ien_q <= 1'b0; sen_q <= 1'b0;
      size_q <= 2'd0; sticky_q <= 1'b0;
      base_hi_q <= 32'd0; base_lo_q <= 28'd0;
      roff_q <= '0; woff_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          SEL_CTRL: begin
            en_q   <= reg_wdata[0];
            fen_q  <= reg_wdata[1];
            ien_q  <= reg_wdata[3];
            sen_q  <= reg_wdata[4];
            size_q <= reg_wdata[9:8];
            if (reg_wdata[16]) sticky_q <= 1'b0;
          end
          SEL_BHI:  base_hi_q <= reg_wdata;
          SEL_BLO:  base_lo_q <= reg_wdata[31:4];
          SEL_ROFF: roff_q <= reg_wdata[OFF_W-1:0] & off_mask;
          SEL_WOFF: woff_q <= reg_wdata[OFF_W-1:0] & off_mask;
          default: ;
        endcase
      end
      if (drop_full) sticky_q <= 1'b1;
      if (req_q && mem_ack) woff_q <= woff_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= 64'd0;
      rec_q  <= 16'd0;
    end else if (accept) begin
      req_q  <= 1'b1;
      addr_q <= {base_hi_q, base_lo_q, 4'd0} + 64'(woff_m);
      rec_q  <= msi_data[15:0];
    end else if (req_q && mem_ack) begin
      req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_queue_ctrl_chk.sv
module msi_queue_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         mem_req,
  input logic         mem_ack,
  input logic [63:0]  mem_addr,
  input logic [127:0] mem_data
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R4
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R4
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[3:0] == 4'd0); // R2
  AST_REC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_data[127:16] == 112'd0); // R3
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !mem_req |=> !mem_req); // R10
endmodule

bind msi_queue_ctrl msi_queue_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/msi_queue_ctrl_test.sv
module msi_queue_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic msi_valid = 1'b0;
  logic [31:0] msi_data = 32'd0;
  logic mem_req, mem_ack = 1'b0, irq;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  localparam logic [63:0] BASE = 64'h0000_0012_3456_7800;
  localparam logic [47:0] VEC [4] = '{
    {16'hA001, 32'h0000_0000}, {16'h00FF, 32'h0000_0010},
    {16'hFFFF, 32'h0000_0020}, {16'h1234, 32'h0000_0030}};

  always #2.5 clk = ~clk;

  msi_queue_ctrl uut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk); msi_data = d; msi_valid = 1'b1;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  task automatic ack();
    mem_ack = 1'b1;
    @(negedge clk); mem_ack = 1'b0;
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reg reset", v, 0); end
    chk("R1 irq reset", irq, 0);
    chk("R1 req reset", mem_req, 0);

    wr(3'd3, 32'h0000_0012);
    wr(3'd4, 32'h3456_780F);
    rd(3'd4, v); chk("R2 base low aligned", v, 32'h3456_7800);
    rd(3'd3, v); chk("R2 base high", v, 32'h12);
    wr(3'd0, 32'h0000_0309);
    rd(3'd0, v); chk("R2 ctrl readback", v, 32'h309);
    wr(3'd0, 32'h0000_0009);

    for (int i = 0; i < 4; i++) begin
      send({16'hBEEF, VEC[i][47:32]});
      chk("R3 req issued", mem_req, 1);
      chk("R3 addr", mem_addr, BASE + 64'(VEC[i][31:0]));
      chk("R3 record", mem_data, {112'd0, VEC[i][47:32]});
      rd(3'd6, v); chk("R4 woff before ack", v, VEC[i][31:0]);
      ack();
      chk("R4 req released", mem_req, 0);
      rd(3'd6, v); chk("R4 woff after ack", v, VEC[i][31:0] + 32'h10);
      chk("R7 irq pending", irq, 1);
    end
    wr(3'd5, 32'h40);
    chk("R7 irq empty", irq, 0);

    send(32'h55);
    @(negedge clk); msi_data = 32'h66; msi_valid = 1'b1;
    @(negedge clk); msi_valid = 1'b0;
    chk("R4 addr held", mem_addr, BASE + 64'h40);
    chk("R4 data held", mem_data, 128'h55);
    ack();
    repeat (2) @(negedge clk);
    chk("R4 busy msg ignored", mem_req, 0);
    rd(3'd6, v); chk("R4 single advance", v, 32'h50);

    wr(3'd5, 32'h100);
    wr(3'd6, 32'h7FF0);
    send(32'h77);
    chk("R5 edge addr", mem_addr, BASE + 64'h7FF0);
    ack();
    rd(3'd6, v); chk("R5 wrap to zero", v, 0);

    wr(3'd0, 32'h109);
    wr(3'd6, 32'h8000);
    rd(3'd6, v); chk("R6 woff 64K", v, 32'h8000);
    wr(3'd0, 32'h9);
    rd(3'd6, v); chk("R6 woff remasked", v, 0);
    wr(3'd5, 32'h1234F);
    rd(3'd5, v); chk("R6 roff masked", v, 32'h2340);
    wr(3'd0, 32'h309);
    wr(3'd5, 32'h3FFFF);
    rd(3'd5, v); chk("R6 roff 256K", v, 32'h3FFF0);

    wr(3'd0, 32'h1B);
    wr(3'd5, 32'h40);
    wr(3'd6, 32'h30);
    chk("R8 irq full", irq, 1);
    send(32'h88);
    repeat (2) @(negedge clk);
    chk("R9 dropped no req", mem_req, 0);
    rd(3'd6, v); chk("R9 woff unchanged", v, 32'h30);
    rd(3'd0, v); chk("R9 sticky set", v, 32'h1001B);
    wr(3'd0, 32'h1001B);
    rd(3'd0, v); chk("R9 sticky cleared", v, 32'h1B);
    wr(3'd0, 32'h3);
    chk("R8 full irq only", irq, 1);
    wr(3'd0, 32'h1);
    chk("R7 irq gated", irq, 0);
    wr(3'd0, 32'h9);
    send(32'h99);
    chk("R9 no stop logs", mem_addr, BASE + 64'h30);
    ack();
    rd(3'd6, v); chk("R9 woff overrun", v, 32'h40);
    chk("R7 irq after overrun", irq, 0);

    wr(3'd0, 32'h0);
    send(32'hAA);
    repeat (2) @(negedge clk);
    chk("R10 disabled ignored", mem_req, 0);
    rd(3'd6, v); chk("R10 woff unchanged", v, 32'h40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule